// File: doc/BRIEF.md
# Alternating Stop-and-Go Keystream Generator

This block produces a pseudo-random keystream, one bit per accepted step, from three Fibonacci linear feedback shift registers of different lengths. A 5-bit control register advances on every accepted step. Its least significant bit, taken before the step, chooses which of two data registers advances on that step: a 7-bit register or an 11-bit register. The other data register holds. The keystream bit is the XOR of the two data registers' least significant bits.

Software or a neighbouring block first loads three seeds with a one-cycle load strobe. It then pulses the step enable once for each keystream bit it wants. A one-cycle valid flag marks each new bit. Reset puts every register at the value 1 and leaves the generator unarmed, so steps are ignored until the first load.

Top module: `altstep_keygen`

## Requirements
- R1: After reset `ks_valid` is low, and `step_en` pulses before the first `load` are ignored: no valid pulse follows them.
- R2: A `load` captures all three seeds at the next clock edge and takes priority over a `step_en` in the same cycle. That step is dropped and gives no valid pulse.
- R3: A seed of all zeros is loaded as the value 1 (only bit 0 set) for that register.
- R4: On each step a register forms a feedback bit as the XOR of its tap bits. It shifts right by one and puts the feedback bit in its top bit. Its output is its bit 0. A polynomial x^N+x^k+1 taps bits k and 0. The defaults are x^5+x^3+1 (control), x^7+x^6+1 (register A) and x^11+x^9+1 (register B).
- R5: On an accepted step where the control output is 1, register A advances and register B holds.
- R6: On an accepted step where the control output is 0, register B advances and register A holds.
- R7: The selection uses the control register's bit 0 as it stands before the step, and the control register advances on every accepted step.
- R8: `ks_bit` always equals bit 0 of register A XOR bit 0 of register B. It therefore shows the new keystream bit in the cycle after a step, and it shows seedA[0]^seedB[0] in the cycle after a load.
- R9: `ks_valid` is high for exactly the one cycle after each accepted step. It is low after cycles with no accepted step.
- R10: No register ever holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Request one generator step |
| load | input | 1 | Seed load strobe, arms the generator |
| seed_ctl | input | 5 | Seed for the control register |
| seed_a | input | 7 | Seed for data register A |
| seed_b | input | 11 | Seed for data register B |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | One-cycle flag for a new keystream bit |

## Verification
A step or load presented before an edge takes effect at that edge. `ks_valid` and the new `ks_bit` are therefore due in the cycle that follows, which is one register stage with no further latency. The driver applies inputs just after a rising edge and pushes the expected bit into a queue at that time. The monitor samples on the falling edge and compares each valid bit with the head of the queue. Ignored steps and loads are checked on the falling edge one cycle after they are applied, where `ks_valid` must be low and `ks_bit` must show the loaded seeds.

// File: rtl/altstep_pkg.sv
`timescale 1ns/1ps
package altstep_pkg;
   // which data register a step moves
   typedef enum logic {
      PICK_B = 1'b0,
      PICK_A = 1'b1
   } pick_e;

   function automatic pick_e pick_from_ctl(input logic ctl_bit);
      return ctl_bit ? PICK_A : PICK_B;
   endfunction
endpackage

// File: rtl/altstep_lfsr.sv
`timescale 1ns/1ps
module altstep_lfsr #(
   parameter int unsigned W        = 5,
   parameter logic [W-1:0] TAPS    = 5'b01001,
   parameter bit          ZERO_FIX = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         adv,
   output logic [W-1:0] state,
   output logic         lsb
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_width
      $error("altstep_lfsr: width below 2");
   end
   if (TAPS[0] != 1'b1) begin : g_bad_taps
      $error("altstep_lfsr: bit 0 must be tapped");
   end

   logic [W-1:0] st_q;
   logic [W-1:0] seed_fix;
   logic [W:0]   xr;

   // feedback: XOR chain over the tapped cells
   assign xr[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
         assign xr[i+1] = xr[i] ^ st_q[i];
      end else begin : g_off
         assign xr[i+1] = xr[i];
      end
   end

   if (ZERO_FIX) begin : g_fix
      assign seed_fix = (seed == '0) ? ONE : seed;
   end else begin : g_raw
      assign seed_fix = seed;
   end

   always_ff @(posedge clk) begin
      if (rst)       st_q <= ONE;
      else if (load) st_q <= seed_fix;
      else if (adv)  st_q <= {xr[W], st_q[W-1:1]};
   end

   assign state = st_q;
   assign lsb   = st_q[0];

   // R10
   nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      st_q != '0);
   // R4
   shift_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && !load) |=> (st_q[W-2:0] == $past(st_q[W-1:1])));
   // R3
   zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
      (load && seed == '0) |=> (st_q == ONE));
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && !adv) |=> $stable(st_q));
endmodule

// File: rtl/altstep_sched.sv
`timescale 1ns/1ps
module altstep_sched
   import altstep_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic step_en,
   input  logic ctl_lsb,
   output logic go,
   output logic adv_a,
   output logic adv_b
);
   logic  armed_q;
   pick_e pick;

   always_ff @(posedge clk) begin
      if (rst)       armed_q <= 1'b0;
      else if (load) armed_q <= 1'b1;
   end

   assign go    = step_en & armed_q & ~load;
   assign pick  = pick_from_ctl(ctl_lsb);
   assign adv_a = go & (pick == PICK_A);
   assign adv_b = go & (pick == PICK_B);

   // R1
   unarmed_chk: assert property (@(posedge clk) disable iff (rst)
      !armed_q |-> !go);
endmodule

// File: rtl/altstep_mix.sv
`timescale 1ns/1ps
module altstep_mix (
   input  logic clk,
   input  logic rst,
   input  logic go,
   input  logic lsb_a,
   input  logic lsb_b,
   output logic ks_bit,
   output logic ks_valid
);
   logic vld_q;

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= go;
   end

   assign ks_bit   = lsb_a ^ lsb_b;
   assign ks_valid = vld_q;
endmodule

// File: rtl/altstep_keygen.sv
`timescale 1ns/1ps
module altstep_keygen #(
   parameter int unsigned   CW    = 5,
   parameter int unsigned   AW    = 7,
   parameter int unsigned   BW    = 11,
   parameter logic [CW-1:0] CTAPS = 5'b01001,
   parameter logic [AW-1:0] ATAPS = 7'b1000001,
   parameter logic [BW-1:0] BTAPS = 11'b01000000001
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_en,
   input  logic          load,
   input  logic [CW-1:0] seed_ctl,
   input  logic [AW-1:0] seed_a,
   input  logic [BW-1:0] seed_b,
   output logic          ks_bit,
   output logic          ks_valid
);
   if (CW == AW || CW == BW || AW == BW) begin : g_bad_len
      $error("altstep_keygen: register lengths must all differ");
   end

   logic [CW-1:0] c_state;
   logic [AW-1:0] a_state;
   logic [BW-1:0] b_state;
   logic c_lsb, a_lsb, b_lsb;
   logic go, adv_a, adv_b;

   altstep_sched u_sched (
      .clk(clk), .rst(rst), .load(load), .step_en(step_en),
      .ctl_lsb(c_lsb), .go(go), .adv_a(adv_a), .adv_b(adv_b)
   );

   altstep_lfsr #(.W(CW), .TAPS(CTAPS), .ZERO_FIX(1'b1)) u_ctl (
      .clk(clk), .rst(rst), .load(load), .seed(seed_ctl), .adv(go),
      .state(c_state), .lsb(c_lsb)
   );

   altstep_lfsr #(.W(AW), .TAPS(ATAPS), .ZERO_FIX(1'b1)) u_rega (
      .clk(clk), .rst(rst), .load(load), .seed(seed_a), .adv(adv_a),
      .state(a_state), .lsb(a_lsb)
   );

   altstep_lfsr #(.W(BW), .TAPS(BTAPS), .ZERO_FIX(1'b1)) u_regb (
      .clk(clk), .rst(rst), .load(load), .seed(seed_b), .adv(adv_b),
      .state(b_state), .lsb(b_lsb)
   );

   altstep_mix u_mix (
      .clk(clk), .rst(rst), .go(go), .lsb_a(a_lsb), .lsb_b(b_lsb),
      .ks_bit(ks_bit), .ks_valid(ks_valid)
   );

   // R5
   a_moves_chk: assert property (@(posedge clk) disable iff (rst)
      (go && c_lsb) |=> $stable(b_state));
   // R6
   b_moves_chk: assert property (@(posedge clk) disable iff (rst)
      (go && !c_lsb) |=> $stable(a_state));
   // R7
   ctl_every_chk: assert property (@(posedge clk) disable iff (rst)
      go |=> (c_state[CW-2:0] == $past(c_state[CW-1:1])));
   // R9
   valid_src_chk: assert property (@(posedge clk) disable iff (rst)
      ks_valid |-> ($past(step_en) && !$past(load)));
   // R2
   load_wins_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> !ks_valid);
endmodule

// File: tb/altstep_keygen_bench.sv
`timescale 1ns/1ps
module altstep_keygen_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic step_en = 1'b0, load = 1'b0;
   logic [4:0]  seed_ctl = '0;
   logic [6:0]  seed_a = '0;
   logic [10:0] seed_b = '0;
   logic ks_bit, ks_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state, taps from R4
   localparam logic [10:0] T_C = 11'b00000001001;
   localparam logic [10:0] T_A = 11'b00001000001;
   localparam logic [10:0] T_B = 11'b01000000001;
   logic [10:0] m_c, m_a, m_b;
   bit armed = 1'b0;
   logic [1:0] exp_q[$];   // {ctl bit, expected ks}

   always #4 clk = ~clk;

   altstep_keygen u_altstep_keygen (
      .clk(clk), .rst(rst), .step_en(step_en), .load(load),
      .seed_ctl(seed_ctl), .seed_a(seed_a), .seed_b(seed_b),
      .ks_bit(ks_bit), .ks_valid(ks_valid)
   );

   function automatic logic [10:0] adv(input logic [10:0] s, input int w,
                                       input logic [10:0] t);
      logic fb;
      fb = ^(s & t);
      return (s >> 1) | (11'(fb) << (w - 1));
   endfunction

   task automatic cycle(input logic st, input logic ld, input logic [4:0] c,
                        input logic [6:0] a, input logic [10:0] b);
      logic cb;
      @(posedge clk); #1;
      step_en = st; load = ld; seed_ctl = c; seed_a = a; seed_b = b;
      if (ld) begin   // R2 R3
         m_c = (c == '0) ? 11'd1 : 11'(c);
         m_a = (a == '0) ? 11'd1 : 11'(a);
         m_b = (b == '0) ? 11'd1 : 11'(b);
         armed = 1'b1;
      end else if (st && armed) begin   // R5 R6 R7
         cb  = m_c[0];
         m_c = adv(m_c, 5, T_C);
         if (cb) m_a = adv(m_a, 7, T_A);
         else    m_b = adv(m_b, 11, T_B);
         exp_q.push_back({cb, m_a[0] ^ m_b[0]});
      end
   endtask

   task automatic idle();
      cycle(1'b0, 1'b0, seed_ctl, seed_a, seed_b);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && ks_valid) begin
         logic [1:0] it;
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected valid", 1, 0);
         end else begin
            it = exp_q.pop_front();
            if (it[1]) check(ks_bit == it[0], "R5 R8 ks after A step", int'(ks_bit), int'(it[0]));
            else       check(ks_bit == it[0], "R6 R8 ks after B step", int'(ks_bit), int'(it[0]));
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(ks_valid == 1'b0, "R1 valid in reset", int'(ks_valid), 0);
      @(posedge clk); #1 rst = 1'b0;

      // R1: steps before the first load are ignored
      cycle(1'b1, 1'b0, 5'd0, 7'd0, 11'd0);
      cycle(1'b1, 1'b0, 5'd0, 7'd0, 11'd0);
      idle();
      @(negedge clk);
      check(ks_valid == 1'b0, "R1 step before load", int'(ks_valid), 0);
      check(ks_bit == 1'b0, "R8 reset states xor", int'(ks_bit), 0);

      // load, then check captured seeds via ks_bit
      cycle(1'b0, 1'b1, 5'h15, 7'h2B, 11'h5A2);
      idle();
      @(negedge clk);
      check(ks_valid == 1'b0, "R2 no valid on load", int'(ks_valid), 0);
      check(ks_bit == 1'b1, "R2 R8 seed lsb xor", int'(ks_bit), 1);

      // back-to-back steps
      for (int i = 0; i < 300; i++) cycle(1'b1, 1'b0, 5'h15, 7'h2B, 11'h5A2);
      idle();
      // gapped steps: valid must drop between them
      for (int i = 0; i < 40; i++) begin
         cycle(1'b1, 1'b0, 5'h15, 7'h2B, 11'h5A2);
         idle();
         @(negedge clk);
         idle();
         @(negedge clk);
         check(ks_valid == 1'b0, "R9 valid one cycle only", int'(ks_valid), 0);
      end

      // load with step in the same cycle: step dropped
      cycle(1'b1, 1'b1, 5'h03, 7'h40, 11'h001);
      idle();
      @(negedge clk);
      check(ks_valid == 1'b0, "R2 load beats step", int'(ks_valid), 0);
      check(ks_bit == 1'b1, "R2 reload lsb xor", int'(ks_bit), 1);
      for (int i = 0; i < 200; i++) cycle(1'b1, 1'b0, 5'h03, 7'h40, 11'h001);
      idle();

      // all-zero seeds replaced by 1
      cycle(1'b0, 1'b1, 5'h00, 7'h00, 11'h000);
      idle();
      @(negedge clk);
      check(ks_bit == 1'b0, "R3 zero seeds become one", int'(ks_bit), 0);
      // long run: R4 polynomials, R7 control, R10 no lock-up
      for (int i = 0; i < 3000; i++) cycle(1'b1, 1'b0, 5'h00, 7'h00, 11'h000);
      idle();
      idle();
      @(negedge clk);
      check(exp_q.size() == 0, "R9 all expected bits seen", exp_q.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule